// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of one memory read or write burst. A single-cycle start pulse captures a full column address, a burst length selector (four or eight beats) and an ordering selector (sequential or interleaved). From the next clock the block presents one column address per cycle. A valid flag marks each beat and a last flag marks the final beat. The low three column bits follow the selected ordering. The bits above them are copied unchanged from the captured address.

In sequential order the two lowest bits count upward and wrap inside an aligned group of four. In an eight-beat burst, once the first group of four is done, the block moves to the other group at the same offset. In interleaved order the low bits are the start address XORed with the beat index. The length and ordering are captured with the start and hold until the burst ends. A start pulse that arrives while a burst is running is dropped.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, valid_o, last_o and busy_o are low.
- R2: A start_i sampled high at a clock edge while busy_o is low begins a burst. From the next cycle valid_o is high and col_o equals the captured start_col_i (beat 0).
- R3: With len8_i=0 and ilv_i=0, beat i (i = 0..3) has col_o[1:0] = (s + i) mod 4, where s is the captured start column.
- R4: With len8_i=1 and ilv_i=0, beat i (i = 0..7) has col_o[1:0] = (s + i) mod 4 and col_o[2] = s[2] XOR (i >= 4). For example, start 5 gives 5,6,7,4,1,2,3,0.
- R5: With ilv_i=1, beat i has col_o[2:0] = s[2:0] XOR i. For example, start 5 in eight beats gives 5,4,7,6,1,0,3,2, and start 3 in four beats gives 3,2,1,0.
- R6: In a four-beat burst, col_o[COL_W-1:2] holds the start value on every beat. In an eight-beat burst, col_o[COL_W-1:3] holds the start value on every beat.
- R7: valid_o stays high for exactly 4 (len8_i=0) or 8 (len8_i=1) consecutive cycles. last_o is high only on the final beat, and valid_o is low in the cycle after it.
- R8: A start_i while busy_o is high is ignored, including a start that coincides with the final beat. The running burst's addresses and length are unchanged, and no burst follows it.
- R9: len8_i and ilv_i are sampled only with an accepted start. Changing them mid-burst has no effect on that burst.
- R10: busy_o is high exactly in the cycles in which valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a burst |
| start_col_i | input | COL_W | Starting column address |
| len8_i | input | 1 | 1 = eight-beat burst, 0 = four-beat burst |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final beat |
| busy_o | output | 1 | A burst is in progress |

## Verification
Two things can land on the same edge: a new start pulse, and the final beat that ends a running burst. The bench holds start_i high, with a different address and inverted length and ordering, through every beat of some bursts, including the last. It then checks that valid_o drops in the cycle after last_o and that no second burst appears. Every start offset, length and ordering is swept with and without this disturbance, and each beat is compared against addresses computed arithmetically.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic {
        LEN_4 = 1'b0,
        LEN_8 = 1'b1
    } blen_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    localparam int unsigned LOW_W = 3;

endpackage

// File: rtl/bcs_order.sv
module bcs_order
    import bcs_pkg::*;
(
    input  logic [LOW_W-1:0] base_i,
    input  logic [LOW_W-1:0] beat_i,
    input  blen_e            len_i,
    input  order_e           order_i,
    output logic [LOW_W-1:0] low_o
);

    logic [1:0] pair_d;
    logic       grp_d;

    always_comb begin
        if (order_i == ORD_ILV) begin
            pair_d = base_i[1:0] ^ beat_i[1:0];
        end else begin
            pair_d = base_i[1:0] + beat_i[1:0];
        end
        if (len_i == LEN_8) begin
            grp_d = base_i[2] ^ beat_i[2];
        end else begin
            grp_d = base_i[2];
        end
        low_o = {grp_d, pair_d};
    end

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  blen_e            len_i,
    input  order_e           order_i,
    output logic             active_o,
    output logic             last_o,
    output logic [LOW_W-1:0] beat_o,
    output logic [COL_W-1:0] base_o,
    output blen_e            len_o,
    output order_e           order_o
);

    localparam logic [LOW_W-1:0] END4 = LOW_W'(3);
    localparam logic [LOW_W-1:0] END8 = LOW_W'(7);

    typedef struct packed {
        logic             active;
        logic [LOW_W-1:0] beat;
        logic [COL_W-1:0] base;
        blen_e            len;
        order_e           order;
    } st_t;

    st_t st_d, st_q;
    logic fin_d;

    always_comb begin
        st_d  = st_q;
        fin_d = st_q.active &&
                (st_q.beat == ((st_q.len == LEN_8) ? END8 : END4));
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active = 1'b1;
                st_d.beat   = '0;
                st_d.base   = start_col_i;
                st_d.len    = len_i;
                st_d.order  = order_i;
            end
        end else if (fin_d) begin
            st_d.active = 1'b0;
            st_d.beat   = '0;
        end else begin
            st_d.beat = st_q.beat + LOW_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, beat: '0, base: '0, len: LEN_4, order: ORD_SEQ};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign last_o   = fin_d;
    assign beat_o   = st_q.beat;
    assign base_o   = st_q.base;
    assign len_o    = st_q.len;
    assign order_o  = st_q.order;

    // Captured configuration must not move while a burst runs
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !fin_d) |=> ($stable(st_q.len) && $stable(st_q.order)));

    // Beat index advances by exactly one while running
    assert_beat_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !fin_d) |=> (st_q.active && st_q.beat == $past(st_q.beat) + LOW_W'(1)));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             len8_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             busy_o
);

    localparam int unsigned HI_W = COL_W - LOW_W;

    logic             act_w;
    logic             fin_w;
    logic [LOW_W-1:0] beat_w;
    logic [COL_W-1:0] base_w;
    blen_e            len_w;
    order_e           ord_w;
    logic [LOW_W-1:0] low_w;

    bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_i       (blen_e'(len8_i)),
        .order_i     (order_e'(ilv_i)),
        .active_o    (act_w),
        .last_o      (fin_w),
        .beat_o      (beat_w),
        .base_o      (base_w),
        .len_o       (len_w),
        .order_o     (ord_w)
    );

    bcs_order u_order (
        .base_i  (base_w[LOW_W-1:0]),
        .beat_i  (beat_w),
        .len_i   (len_w),
        .order_i (ord_w),
        .low_o   (low_w)
    );

    logic [HI_W-1:0] hi_w;
    assign hi_w    = base_w[COL_W-1:LOW_W];
    assign col_o   = {hi_w, low_w};
    assign valid_o = act_w;
    assign busy_o  = act_w;
    assign last_o  = fin_w;

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (valid_o && col_o == $past(start_col_i)));

    assert_last_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o);

    assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    assert_upper_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> $stable(col_o[COL_W-1:LOW_W]));

    assert_bit2_hold4_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && len_w == LEN_4) |=> $stable(col_o[2]));

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && ord_w == ORD_SEQ) |=> (col_o[1:0] == $past(col_o[1:0]) + 2'd1));

    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !last_o) |=> (valid_o && $stable(col_o[COL_W-1:LOW_W])));

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

    localparam int unsigned COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             len8_i = 1'b0;
    logic             ilv_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, busy_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len8_i(len8_i), .ilv_i(ilv_i), .col_o(col_o), .valid_o(valid_o),
        .last_o(last_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int i, input bit l8, input bit ilv);
        int low;
        int hi;
        hi = s & ~7;
        if (ilv) begin
            low = (s & 7) ^ i;
        end else if (l8) begin
            low = (((s >> 2) & 1) ^ (i / 4)) * 4 + (((s & 3) + i) % 4);
        end else begin
            low = (s & 4) + (((s & 3) + i) % 4);
        end
        return hi + low;
    endfunction

    task automatic run_burst(input int s, input bit l8, input bit ilv, input bit disturb);
        int n;
        n = l8 ? 8 : 4;
        start_col_i = COL_W'(s);
        len8_i = l8;
        ilv_i = ilv;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            chk(valid_o && busy_o, "R10", int'(busy_o), 1);
            chk(int'(col_o) == exp_col(s, i, l8, ilv),
                ilv ? "R5" : (l8 ? "R4" : "R3"), int'(col_o), exp_col(s, i, l8, ilv));
            chk(last_o == (i == n - 1), "R7", int'(last_o), int'(i == n - 1));
            if (disturb) begin
                // R8, R9: new start and flipped config while running
                start_i = 1'b1;
                start_col_i = ~COL_W'(s);
                len8_i = ~l8;
                ilv_i = ~ilv;
            end
            @(negedge clk);
        end
        chk(!valid_o && !busy_o, disturb ? "R8" : "R7", int'(valid_o), 0);
        start_i = 1'b0;
        @(negedge clk);
        chk(!valid_o, disturb ? "R8" : "R7", int'(valid_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!valid_o && !last_o && !busy_o, "R1", int'({valid_o, last_o, busy_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid_o, "R1", int'(valid_o), 0);
        for (int k = 0; k < 4 * 8 * 2 * 2; k++) begin
            int s;
            s = ((k * 149) & 10'h3F8) | (k & 7);
            // R2, R6: start value and upper bits checked through exp_col
            run_burst(s, (k >> 3) & 1, (k >> 4) & 1, (k >> 5) & 1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule